// File: doc/BRIEF.md
# Cascadable LCD Segment Driver Core

This block is the digital part of an 80-output LCD segment driver. Display data arrives on a slow data clock and is taken in on that clock's falling edge. The data comes either one bit per edge (serial mode) or four bits per edge (parallel mode). Bits enter an 80-bit shift register only while the chip-disable input is low. A falling edge on the load strobe moves the shift register into an output latch. Every output then presents a 2-bit level code to the analog switches outside this block.

Several drivers can be chained to form a wider row. Each driver counts the beats it has accepted. Once its line is full, it drops its cascade output, which feeds the chip-disable input of the next driver. From then on it ignores the data clock until the next load strobe. The level code of each output depends on three things: the latched bit, an alternation input that swaps the drive polarity every frame, and a display-enable input that forces every output to the blank level.

All data-clock and strobe edges are found by sampling those inputs on a fast system clock, so the whole core runs in one clock domain with a synchronous active-high reset.

Top module: `lcd_seg_driver`

## Requirements
- R1: When reset is asserted on a clock edge, the shift register, the latch and the beat count are cleared, and the cascade output is high after that edge.
- R2: In serial mode (`par_mode`=0), each accepted falling edge of `dclk` shifts in `sdi` as one bit. After a load, output 1 (code bits [1:0]) shows the earliest of the last 80 bits accepted and output 80 shows the latest. Rising edges of `dclk` shift nothing.
- R3: In parallel mode (`par_mode`=1), each accepted falling edge shifts in four bits in the order `sdi`, `par_in[2]`, `par_in[1]`, `par_in[0]`. After a full line, the first beat's `sdi` appears at output 1 and its `par_in[0]` at output 4.
- R4: While `chip_dis` is high, falling edges of `dclk` neither shift data nor advance the beat count.
- R5: The cascade output goes low after 80 accepted beats in serial mode or 20 in parallel mode, and not one beat earlier. While it is low, further `dclk` edges change nothing until the next load.
- R6: A falling edge of `load` copies the shift register into the latch, clears the beat count and raises the cascade output. Between loads, the output codes do not change with incoming data.
- R7: With `disp_en` high, the code of each output is set by the alternation input and the latched bit: m=0,q=0 gives 2'b01; m=0,q=1 gives 2'b00; m=1,q=0 gives 2'b10; m=1,q=1 gives 2'b11.
- R8: With `disp_en` low, every output gives code 2'b00, whatever the data or the alternation input.
- R9: With parameter `MIRROR`=1, the output numbering is reversed: the code for output k appears where output 81-k would appear in the default build.
- R10: When a `load` falling edge and a `dclk` falling edge are seen in the same cycle, the load takes effect and that data beat is dropped and not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| dclk | input | 1 | Data clock; data is taken on its falling edge |
| chip_dis | input | 1 | High blocks data intake |
| load | input | 1 | Line strobe; its falling edge latches the line |
| par_mode | input | 1 | 1 = four bits per beat, 0 = one bit per beat |
| sdi | input | 1 | Serial data, and first bit of a parallel beat |
| par_in | input | 3 | Remaining parallel bits; [2] goes before [0] |
| alt_m | input | 1 | Frame alternation input |
| disp_en | input | 1 | Low forces every output to the blank code |
| cas_out | output | 1 | High while accepting data; low when the line is full |
| drive_code | output | 160 | Two bits per output; output k+1 at bits [2k+1:2k] |

## Verification
Whole lines are sent in both serial and parallel mode using different bit patterns, so a swapped nibble order or a reversed output order shows up as wrong codes. Beats sent while chip-disable is high, beats past a full line, and a beat that arrives together with the load strobe must each leave no trace in the latched line or in the point where the cascade output falls. Each latched line is shown under both alternation phases and with the display blanked, which separates the four-level table from the forced blank state. A mirrored copy of the core runs on the same inputs and must show the same line in reverse.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

    typedef enum logic [1:0] {
        LVL_SEL_A   = 2'b00,
        LVL_UNSEL_A = 2'b01,
        LVL_UNSEL_B = 2'b10,
        LVL_SEL_B   = 2'b11
    } drive_lvl_e;

    typedef struct packed {
        logic dclk;
        logic load;
    } strobe_t;

    function automatic drive_lvl_e pick_level(input logic en, input logic m, input logic q);
        drive_lvl_e lvl;
        if (!en) begin
            lvl = LVL_SEL_A;
        end else begin
            unique case ({m, q})
                2'b00:   lvl = LVL_UNSEL_A;
                2'b01:   lvl = LVL_SEL_A;
                2'b10:   lvl = LVL_UNSEL_B;
                default: lvl = LVL_SEL_B;
            endcase
        end
        return lvl;
    endfunction

endpackage

// File: rtl/lcd_seg_fall.sv
module lcd_seg_fall
    import lcd_seg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t lvl_in,
    output strobe_t fall
);
    strobe_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_in;
    end

    assign fall = prev_q & ~lvl_in;
endmodule

// File: rtl/lcd_seg_shift.sv
module lcd_seg_shift #(
    parameter int NUM_OUT = 80,
    parameter int PAR_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               beat_fall,
    input  logic               load_fall,
    input  logic               chip_dis,
    input  logic               par_mode,
    input  logic               sdi,
    input  logic [PAR_W-2:0]   par_in,
    output logic [NUM_OUT-1:0] shift_q,
    output logic               cas_out
);
    localparam int PAR_BEATS = NUM_OUT / PAR_W;
    localparam int CNT_W     = $clog2(NUM_OUT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term;
    logic             full;
    logic             accept;

    assign term   = par_mode ? CNT_W'(PAR_BEATS) : CNT_W'(NUM_OUT);
    assign full   = (cnt_q >= term);
    assign accept = beat_fall && !chip_dis && !full && !load_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (load_fall) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (par_mode) shift_q <= {shift_q[NUM_OUT-PAR_W-1:0], sdi, par_in};
            else          shift_q <= {shift_q[NUM_OUT-2:0], sdi};
        end
    end

    assign cas_out = !full;
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
    parameter int NUM_OUT = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_fall,
    input  logic [NUM_OUT-1:0] shift_q,
    output logic [NUM_OUT-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst)            latch_q <= '0;
        else if (load_fall) latch_q <= shift_q;
    end
endmodule

// File: rtl/lcd_seg_enc.sv
module lcd_seg_enc
    import lcd_seg_pkg::*;
#(
    parameter int NUM_OUT = 80,
    parameter bit MIRROR  = 1'b0
) (
    input  logic                 alt_m,
    input  logic                 disp_en,
    input  logic [NUM_OUT-1:0]   latch_q,
    output logic [2*NUM_OUT-1:0] drive_code
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_pin
        localparam int SRC = MIRROR ? k : NUM_OUT - 1 - k;
        drive_lvl_e lvl;
        always_comb lvl = pick_level(disp_en, alt_m, latch_q[SRC]);
        assign drive_code[2*k +: 2] = lvl;
    end
endmodule

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver
    import lcd_seg_pkg::*;
#(
    parameter int NUM_OUT = 80,
    parameter int PAR_W   = 4,
    parameter bit MIRROR  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dclk,
    input  logic                 chip_dis,
    input  logic                 load,
    input  logic                 par_mode,
    input  logic                 sdi,
    input  logic [PAR_W-2:0]     par_in,
    input  logic                 alt_m,
    input  logic                 disp_en,
    output logic                 cas_out,
    output logic [2*NUM_OUT-1:0] drive_code
);
    strobe_t              strobe_lvl;
    strobe_t              strobe_fall;
    logic                 load_fall;
    logic [NUM_OUT-1:0]   shift_q;
    logic [NUM_OUT-1:0]   latch_q;

    assign strobe_lvl.dclk = dclk;
    assign strobe_lvl.load = load;
    assign load_fall       = strobe_fall.load;

    lcd_seg_fall u_fall (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (strobe_lvl),
        .fall   (strobe_fall)
    );

    lcd_seg_shift #(.NUM_OUT(NUM_OUT), .PAR_W(PAR_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .beat_fall (strobe_fall.dclk),
        .load_fall (load_fall),
        .chip_dis  (chip_dis),
        .par_mode  (par_mode),
        .sdi       (sdi),
        .par_in    (par_in),
        .shift_q   (shift_q),
        .cas_out   (cas_out)
    );

    lcd_seg_latch #(.NUM_OUT(NUM_OUT)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .load_fall (load_fall),
        .shift_q   (shift_q),
        .latch_q   (latch_q)
    );

    lcd_seg_enc #(.NUM_OUT(NUM_OUT), .MIRROR(MIRROR)) u_enc (
        .alt_m      (alt_m),
        .disp_en    (disp_en),
        .latch_q    (latch_q),
        .drive_code (drive_code)
    );
endmodule

// File: rtl/lcd_seg_driver_chk.sv
module lcd_seg_driver_chk #(
    parameter int NUM_OUT = 80
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 load_fall,
    input logic                 chip_dis,
    input logic                 cas_out,
    input logic                 alt_m,
    input logic                 disp_en,
    input logic [NUM_OUT-1:0]   shift_q,
    input logic [NUM_OUT-1:0]   latch_q,
    input logic [2*NUM_OUT-1:0] drive_code
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (latch_q == '0 && shift_q == '0 && cas_out));

    a_r4_disabled_no_shift: assert property (@(posedge clk) disable iff (rst)
        (chip_dis && !load_fall) |=> $stable(shift_q));

    a_r5_full_no_shift: assert property (@(posedge clk) disable iff (rst)
        (!cas_out && !load_fall) |=> $stable(shift_q));

    a_r6_load_reopens: assert property (@(posedge clk) disable iff (rst)
        load_fall |=> cas_out);

    a_r6_latch_copy: assert property (@(posedge clk) disable iff (rst)
        load_fall |=> (latch_q == $past(shift_q)));

    a_r6_latch_holds: assert property (@(posedge clk) disable iff (rst)
        !load_fall |=> $stable(latch_q));

    a_r7_msb_follows_m: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> (drive_code[1] == alt_m));

    a_r8_blank_all: assert property (@(posedge clk) disable iff (rst)
        !disp_en |-> (drive_code == '0));
endmodule

bind lcd_seg_driver lcd_seg_driver_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_fall  (load_fall),
    .chip_dis   (chip_dis),
    .cas_out    (cas_out),
    .alt_m      (alt_m),
    .disp_en    (disp_en),
    .shift_q    (shift_q),
    .latch_q    (latch_q),
    .drive_code (drive_code)
);

// File: tb/sim_lcd_seg_driver.sv
module sim_lcd_seg_driver;
    localparam int N = 80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dclk = 1'b0, chip_dis = 1'b0, load = 1'b0, par_mode = 1'b0;
    logic sdi = 1'b0, alt_m = 1'b0, disp_en = 1'b1;
    logic [2:0] par_in = '0;
    logic cas0, cas1;
    logic [2*N-1:0] code0, code1;

    always #4 clk = ~clk;

    lcd_seg_driver #(.NUM_OUT(N), .PAR_W(4), .MIRROR(1'b0)) u0 (
        .clk(clk), .rst(rst), .dclk(dclk), .chip_dis(chip_dis), .load(load),
        .par_mode(par_mode), .sdi(sdi), .par_in(par_in), .alt_m(alt_m),
        .disp_en(disp_en), .cas_out(cas0), .drive_code(code0));

    lcd_seg_driver #(.NUM_OUT(N), .PAR_W(4), .MIRROR(1'b1)) u1 (
        .clk(clk), .rst(rst), .dclk(dclk), .chip_dis(chip_dis), .load(load),
        .par_mode(par_mode), .sdi(sdi), .par_in(par_in), .alt_m(alt_m),
        .disp_en(disp_en), .cas_out(cas1), .drive_code(code1));

    typedef struct {
        string          req;
        logic [2*N-1:0] c0;
        logic [2*N-1:0] c1;
        logic           cas;
    } item_t;

    item_t sb[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit recv[N];
    bit lat[N];
    int bcnt = 0;

    function automatic logic [1:0] lvl(bit en, bit m, bit q);
        if (!en) return 2'b00;
        case ({m, q})
            2'b00:   return 2'b01;
            2'b01:   return 2'b00;
            2'b10:   return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic bit pat(int seed, int i);
        return ((i * seed + (i >> 2) * 3 + seed) % 3) == 0;
    endfunction

    task automatic push_bit(bit b);
        for (int k = 0; k < N - 1; k++) recv[k] = recv[k + 1];
        recv[N - 1] = b;
    endtask

    task automatic beat(bit s, logic [2:0] p);
        bit acc;
        acc = !chip_dis && (bcnt < (par_mode ? N / 4 : N));
        @(negedge clk); sdi = s; par_in = p; dclk = 1'b1;
        @(negedge clk); dclk = 1'b0;
        @(negedge clk);
        if (acc) begin
            bcnt++;
            push_bit(s);
            if (par_mode) begin
                push_bit(p[2]); push_bit(p[1]); push_bit(p[0]);
            end
        end
    endtask

    task automatic do_load();
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        lat = recv; bcnt = 0;
    endtask

    task automatic load_with_beat(bit s);
        @(negedge clk); load = 1'b1; dclk = 1'b1; sdi = s;
        @(negedge clk); load = 1'b0; dclk = 1'b0;
        @(negedge clk);
        lat = recv; bcnt = 0;
    endtask

    task automatic expect_now(string req);
        item_t it;
        it.req = req;
        for (int k = 0; k < N; k++) begin
            it.c0[2*k +: 2] = lvl(disp_en, alt_m, lat[k]);
            it.c1[2*k +: 2] = lvl(disp_en, alt_m, lat[N - 1 - k]);
        end
        it.cas = (bcnt < (par_mode ? N / 4 : N));
        sb.push_back(it);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (code0 !== it.c0) begin
                    errors++;
                    $display("FAIL %s codes: actual %h expected %h", it.req, code0, it.c0);
                end
                checks++;
                if (code1 !== it.c1) begin
                    errors++;
                    $display("FAIL %s R9 mirrored codes: actual %h expected %h", it.req, code1, it.c1);
                end
                checks++;
                if (cas0 !== it.cas || cas1 !== it.cas) begin
                    errors++;
                    $display("FAIL %s cascade: actual %b/%b expected %b", it.req, cas0, cas1, it.cas);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1 reset m=0");
        alt_m = 1'b1;
        expect_now("R1 reset m=1");
        alt_m = 1'b0;

        // serial line, seed 5
        for (int i = 0; i < N - 1; i++) beat(pat(5, i), 3'b000);
        expect_now("R5 serial 79 beats still open; R6 outputs unchanged");
        beat(pat(5, N - 1), 3'b000);
        expect_now("R5 serial full after 80");
        for (int i = 0; i < 6; i++) beat(1'b1, 3'b000);
        expect_now("R5 extra serial beats ignored");
        do_load();
        expect_now("R2 serial line latched; R6 reopen");
        alt_m = 1'b1;
        expect_now("R7 serial line m=1");
        disp_en = 1'b0;
        expect_now("R8 blank m=1");
        alt_m = 1'b0;
        expect_now("R8 blank m=0");
        disp_en = 1'b1;

        // parallel line
        par_mode = 1'b1;
        for (int j = 0; j < N / 4 - 1; j++)
            beat(pat(7, 4 * j), {pat(7, 4 * j + 1), pat(7, 4 * j + 2), pat(7, 4 * j + 3)});
        expect_now("R5 parallel 19 beats still open");
        beat(1'b1, 3'b001);
        expect_now("R5 parallel full after 20");
        for (int j = 0; j < 4; j++) beat(1'b0, 3'b110);
        do_load();
        expect_now("R3 parallel line latched, extra beats R5 dropped");
        alt_m = 1'b1;
        expect_now("R7 parallel line m=1");
        alt_m = 1'b0;
        par_mode = 1'b0;

        // chip disabled beats
        chip_dis = 1'b1;
        for (int i = 0; i < 12; i++) beat(1'b1, 3'b000);
        expect_now("R4 disabled beats not counted");
        chip_dis = 1'b0;
        for (int i = 0; i < N; i++) beat(pat(11, i), 3'b000);
        expect_now("R4 line full after exactly 80 enabled beats");
        do_load();
        expect_now("R4 line has no disabled bits");

        // load coinciding with a data beat
        for (int i = 0; i < N - 1; i++) beat(pat(13, i), 3'b000);
        load_with_beat(1'b1);
        expect_now("R10 coincident beat dropped");
        for (int i = 0; i < N - 1; i++) beat(pat(2, i), 3'b000);
        expect_now("R10 dropped beat not counted");
        beat(1'b0, 3'b000);
        do_load();
        expect_now("R2 second serial line latched");

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule